// File: doc/BRIEF.md
# Inverting Parallel Port with Selectable Change Interrupt

This block is a 16-channel parallel port reached through a small register bus. The port is split into two byte-wide data registers, a low byte at address 0 and a high byte at address 1. Each register can be read or written on its own. A wide (16-bit) access at address 0 reaches both registers in one bus cycle. Between register bits and connector pins every bit is inverted. A 1 written to an output bit pulls its pin low. A low level on an input pin reads back as 1.

Input pins pass through a synchroniser before they are read or watched for edges. A two-bit static select picks one of four candidate pins, pins 0 to 3 by default, as the interrupt source. A mode input chooses between two edge rules: falling edges only, or both edges. A qualifying edge sets a sticky interrupt flag. Any read of either data register clears the flag, unless a new qualifying edge arrives in the same cycle.

Top module: `inv_pport`

## Requirements
- R1: After reset every output register bit is 0, so every `port_out` pin sits high. In general `port_out[i]` is the inverse of output register bit i.
- R2: A read returns the inverted, synchronised input pins. Register bit i is 1 when pin i is low and 0 when it is high. A pin change is visible to a read issued from the 2nd rising edge after the change onward.
- R3: Byte lanes follow the address. Address 0 uses data bits 7:0 for pins 7:0, and address 1 uses data bits 15:8 for pins 15:8. A byte write changes only its own lane. A byte read returns 0 on the other lane.
- R4: A wide access (`bus_wide`=1) at address 0 writes or reads both lanes in one cycle. A wide access at address 1 acts as a byte access to the high lane.
- R5: `irq_sel` value k makes pin k (IRQ_BASE+k) the only interrupt source. Edges on any other pin never set `irq`.
- R6: With `irq_both`=0 only a high-to-low transition of the selected pin sets `irq`. A low-to-high transition does not.
- R7: With `irq_both`=1 both transitions of the selected pin set `irq`. The flag rises at the 3rd rising edge after the pin change.
- R8: `irq` stays set until a read of either data register. A write does not clear it. A read with no new edge clears it at that read's clock edge.
- R9: When a qualifying edge is detected in the same cycle as a clearing read, `irq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 low byte, 1 high byte |
| bus_wide | input | 1 | 16-bit access when 1 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; also clears the interrupt |
| bus_wdata | input | 16 | Write data, lanes as in R3 |
| bus_rdata | output | 16 | Registered read data, valid after the read edge |
| irq_sel | input | 2 | Interrupt source pin select |
| irq_both | input | 1 | 1: both edges, 0: falling only |
| port_in | input | 16 | Connector input pin levels |
| port_out | output | 16 | Connector output pin levels |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the block with its default parameters: two byte lanes, a two-stage synchroniser and candidate pins 0 to 3. With these values all four lane decodes can be reached, including the wide access at the high address. The exact three-edge interrupt latency can be tested, which makes the coincident edge-and-read case hit on a known cycle. Pin 5 lies outside the candidate window, so the bench uses it to show that non-selected pins are ignored, while pin 2 serves as the selected source.

// File: rtl/inv_pport_pkg.sv
package inv_pport_pkg;
   typedef enum logic { EDGE_FALL = 1'b0, EDGE_BOTH = 1'b1 } edge_mode_e;

   function automatic logic lane_hit(input int lane, input logic addr, input logic wide);
      if (wide && addr == 1'b0) return 1'b1;
      return (lane == int'(addr));
   endfunction
endpackage

// File: rtl/inv_pport_sync.sv
module inv_pport_sync #(
   parameter int WIDTH   = 16,
   parameter int STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("inv_pport_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[s] <= {WIDTH{RST_LVL}};
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/inv_pport_edge.sv
module inv_pport_edge
   import inv_pport_pkg::*;
#(
   parameter int N_SRC   = 4,
   parameter int SEL_W   = $clog2(N_SRC),
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] lvl,
   input  logic [SEL_W-1:0] sel,
   input  edge_mode_e       mode,
   input  logic             clr,
   output logic             irq
);
   if (N_SRC < 2) begin : g_bad_src
      $error("inv_pport_edge: N_SRC must be at least 2");
   end

   logic [N_SRC-1:0] prev;
   logic [N_SRC-1:0] fall, chg;
   logic             evt;
   logic             flag;

   for (genvar i = 0; i < N_SRC; i++) begin : g_det
      assign fall[i] = prev[i] & ~lvl[i];
      assign chg[i]  = prev[i] ^ lvl[i];
   end

   always_comb begin
      evt = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (SEL_W'(i) == sel) evt = (mode == EDGE_BOTH) ? chg[i] : fall[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev <= {N_SRC{RST_LVL}};
         flag <= 1'b0;
      end else begin
         prev <= lvl;
         flag <= evt | (flag & ~clr);
      end
   end

   assign irq = flag;

   // R8: flag holds without a read
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);
   // R8: read with no new edge clears
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag && clr && !evt |=> !flag);
   // R9: an edge is never lost, even when a read coincides
   a_r9_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> flag);
   // R6: in falling mode the flag only rises after a high sample
   a_r6_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) && $past(mode) == EDGE_FALL |-> $past(prev[sel]) && !$past(lvl[sel]));
endmodule

// File: rtl/inv_pport_regs.sv
module inv_pport_regs
   import inv_pport_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2,
   localparam int WIDTH    = BYTE_W * NUM_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr,
   input  logic             wide,
   input  logic             wr,
   input  logic             rd,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_lvl,
   output logic [WIDTH-1:0] rdata,
   output logic [WIDTH-1:0] out_bits
);
   if (NUM_BYTES != 2) begin : g_bad_lanes
      $error("inv_pport_regs: a one-bit address reaches exactly two lanes");
   end

   logic [NUM_BYTES-1:0] be;
   logic [WIDTH-1:0]     out_q;
   logic [WIDTH-1:0]     rd_q;

   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      localparam int LO = b * BYTE_W;
      assign be[b] = lane_hit(b, addr, wide);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q[LO +: BYTE_W] <= '0;
            rd_q[LO +: BYTE_W]  <= '0;
         end else begin
            if (wr && be[b]) out_q[LO +: BYTE_W] <= wdata[LO +: BYTE_W];
            if (rd) rd_q[LO +: BYTE_W] <= be[b] ? ~pin_lvl[LO +: BYTE_W] : '0;
         end
      end

      // R3: a lane not addressed keeps its contents across a write
      a_r3_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
         wr && !be[b] |=> $stable(out_q[LO +: BYTE_W]));
   end

   assign out_bits = out_q;
   assign rdata    = rd_q;

   // R4: a wide access at address 0 enables every lane
   a_r4_wide_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr || rd) && wide && !addr |-> &be);
   // R3: byte accesses enable exactly one lane
   a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (wr || rd) && !(wide && !addr) |-> $onehot0(be) && |be);
endmodule

// File: rtl/inv_pport.sv
module inv_pport
   import inv_pport_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int NUM_BYTES = 2,
   parameter int SYNC_STG  = 2,
   parameter int N_SRC     = 4,
   parameter int IRQ_BASE  = 0,
   localparam int WIDTH    = BYTE_W * NUM_BYTES,
   localparam int SEL_W    = $clog2(N_SRC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_addr,
   input  logic             bus_wide,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [SEL_W-1:0] irq_sel,
   input  logic             irq_both,
   input  logic [WIDTH-1:0] port_in,
   output logic [WIDTH-1:0] port_out,
   output logic             irq
);
   if (IRQ_BASE + N_SRC > WIDTH) begin : g_bad_window
      $error("inv_pport: interrupt source window exceeds port width");
   end

   logic [WIDTH-1:0] lvl;
   logic [WIDTH-1:0] out_bits;

   inv_pport_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG), .RST_LVL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(port_in), .q(lvl));

   inv_pport_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wide(bus_wide),
      .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .pin_lvl(lvl),
      .rdata(bus_rdata), .out_bits(out_bits));

   inv_pport_edge #(.N_SRC(N_SRC), .RST_LVL(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(lvl[IRQ_BASE +: N_SRC]), .sel(irq_sel),
      .mode(irq_both ? EDGE_BOTH : EDGE_FALL), .clr(bus_rd), .irq(irq));

   assign port_out = ~out_bits;

   // R1: pins sit high right after reset
   a_r1_reset_high: assert property (@(posedge clk)
      !rst_n |=> port_out == '1);
endmodule

// File: tb/test_inv_pport.sv
`timescale 1ns/1ps
module test_inv_pport;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0, bus_wide = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  irq_sel = 2'd2;
   logic        irq_both = 1'b0;
   logic [15:0] port_in = 16'hFFFF;
   logic [15:0] port_out;
   logic        irq;

   int vecs = 0, errs = 0, cycles = 0;
   logic [15:0] q_exp[$];
   string       q_tag[$];
   logic [15:0] out_model = '0;

   always #2 clk = ~clk;

   inv_pport i_inv_pport (.*);

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rd_exp(input logic a, input logic w);
      logic [15:0] v = ~port_in;
      if (w && !a) return v;
      return a ? {v[15:8], 8'h00} : {8'h00, v[7:0]};
   endfunction

   task automatic do_read(input logic a, input logic w, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wide = w; bus_rd = 1'b1;
      q_exp.push_back(rd_exp(a, w));
      q_tag.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_write(input logic a, input logic w, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wide = w; bus_wr = 1'b1; bus_wdata = d;
      if (w && !a) out_model = d;
      else if (a) out_model[15:8] = d[15:8];
      else out_model[7:0] = d[7:0];
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic set_pins(input logic [15:0] p);
      @(negedge clk);
      port_in = p;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   // monitor: pops the expected read result after each read edge
   always @(posedge clk) begin
      if (bus_rd && rst_n) begin
         #1;
         if (q_exp.size() == 0) begin
            vecs++; errs++;
            $display("FAIL scoreboard: actual %h expected none", bus_rdata);
         end else begin
            check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errs++;
         $display("FAIL watchdog: actual %0d expected below 100000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pins high", port_out, 16'hFFFF);
      check("R8 reset irq low", {15'd0, irq}, 16'd0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // R2/R3/R4 reads
      do_read(1'b0, 1'b1, "R2 idle-high pins read 0");
      set_pins(16'h5AC3);
      do_read(1'b0, 1'b0, "R3 low byte read");
      do_read(1'b1, 1'b0, "R3 high byte read");
      do_read(1'b0, 1'b1, "R4 wide read at 0");
      do_read(1'b1, 1'b1, "R4 wide read at 1 is high only");
      set_pins(16'hFFFF);

      // R1/R3/R4 writes
      do_write(1'b0, 1'b0, 16'hAB12);
      check("R3 low byte write", port_out, ~out_model);
      do_write(1'b1, 1'b0, 16'h34CD);
      check("R3 high byte write", port_out, ~out_model);
      do_write(1'b0, 1'b1, 16'hF00F);
      check("R4 wide write", port_out, ~out_model);
      do_write(1'b1, 1'b1, 16'h0E77);
      check("R4 wide write at 1 high only", port_out, ~out_model);
      check("R1 inverted pins", port_out, 16'hF1F0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R8 no irq yet", {15'd0, irq}, 16'd0);

      // R6 falling mode on pin 2
      irq_sel = 2'd2; irq_both = 1'b0;
      set_pins(16'hFFFB);
      check("R6 falling edge sets irq", {15'd0, irq}, 16'd1);
      do_write(1'b0, 1'b0, 16'h0000);
      check("R8 write keeps irq", {15'd0, irq}, 16'd1);
      do_read(1'b0, 1'b0, "R8 clearing read data");
      check("R8 read clears irq", {15'd0, irq}, 16'd0);
      set_pins(16'hFFFF);
      check("R6 rising edge ignored", {15'd0, irq}, 16'd0);

      // R5 other pins ignored
      set_pins(16'hFFDF);
      set_pins(16'hFFFF);
      check("R5 pin 5 ignored", {15'd0, irq}, 16'd0);
      irq_sel = 2'd1;
      set_pins(16'hFFFB);
      check("R5 pin 2 ignored when pin 1 selected", {15'd0, irq}, 16'd0);
      set_pins(16'hFFFF);
      irq_sel = 2'd2;

      // R7 both edges, exact latency
      irq_both = 1'b1;
      @(negedge clk); port_in = 16'hFFFB;
      @(posedge clk); @(posedge clk); #1;
      check("R7 no irq after 2 edges", {15'd0, irq}, 16'd0);
      @(posedge clk); #1;
      check("R7 irq at 3rd edge", {15'd0, irq}, 16'd1);
      do_read(1'b1, 1'b0, "R8 high byte read clears");
      check("R8 high read clears irq", {15'd0, irq}, 16'd0);
      set_pins(16'hFFFF);
      check("R7 rising edge sets irq", {15'd0, irq}, 16'd1);

      // R9 edge coincides with clearing read
      @(negedge clk); port_in = 16'hFFFB;
      @(posedge clk); @(posedge clk);
      do_read(1'b0, 1'b1, "R9 coincident read data");
      check("R9 edge wins over read", {15'd0, irq}, 16'd1);
      do_read(1'b0, 1'b0, "R9 follow-up read");
      check("R9 second read clears", {15'd0, irq}, 16'd0);

      repeat (3) @(posedge clk);
      vecs++;
      if (q_exp.size() != 0) begin
         errs++;
         $display("FAIL scoreboard drain: actual %0d expected 0", q_exp.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule